// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a countdown watchdog reached over a small 16-bit register bus that runs in the same clock domain as the timer. A slow time base arrives as a single-cycle enable pulse (nominally one pulse per 10 ms). Software keeps the system alive by writing a key value that reloads the countdown from a programmed limit. If the countdown runs out, the block drives a system reset pulse of fixed length. It also sets a sticky timed-out status that the pulse does not clear, reloads itself and keeps counting.

Each control action only takes effect when the written word matches a 16-bit key. Stopping the timer takes two keyed writes to two registers in sequence. One tick before the count runs out, an early-warning event is raised, and it reaches the interrupt output when it is unmasked. While a debug probe is attached the countdown pauses, unless software has chosen to keep it running. The remaining count can be read at any time. A flag bit marks a read taken in the cycle where a tick changes the value.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, the count and the limit both equal DEF_TIMEOUT, the disable register (0x0C) reads 0xDABE, status reads 0x0000, the event bit is 0, irq_o and sys_rst_o are low, and ticks do not change the count while stopped.
- R2: Writing 0xFEED to offset 0x00 reloads the count from the limit. Any other value written there leaves the count unchanged.
- R3: The limit at offset 0x04 keeps bits 14:0 of a write, drops bit 15, and reads back zero-extended.
- R4: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C stops the timer, after which 0x0C reads 0xDABE. While running it reads 0x0000. A 0xCAFE write with no arming write before it has no effect. Any other value written to 0x0C cancels the arming, so the sequence must start again at 0x08.
- R5: Writing 0xACED to 0x1C starts a stopped timer. It resumes from the count it held when stopped.
- R6: A tick that arrives while running with count 1 or 0 is an expiry. On expiry, sys_rst_o goes high on the next clock edge for exactly RST_CYCLES cycles, status (0x10) becomes 0xCFE8, and the count reloads from the limit and keeps running. The reset pulse does not clear status. Status returns to 0x0000 only on a write of 0xE8B4, and other values written there are ignored.
- R7: Offset 0x14 returns the count in bits 14:0. Bit 15 is 1 in a cycle where a tick decrements the count, and the count shown in that cycle is the value before the decrement.
- R8: At 0x18, bit 1 reads dbg_active and bit 0 is a writable keep-alive bit. While dbg_active is high and bit 0 is 0, ticks do not change the count. With bit 0 set, counting proceeds.
- R9: A tick that takes a running count from 2 to 1 sets the event bit, bit 0 of 0x20. Writing 1 to that bit clears it. irq_o is high exactly while the event bit and the mask bit (bit 0 of 0x24) are both 1.
- R10: Writing 1 to bit 0 of 0x28 sets the event bit. The register itself reads 0.
- R11: Reads of 0x00, 0x08, 0x1C, 0x28, of offsets above 0x28 and of addresses with bits 1:0 not zero return 0x0000. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and timer |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | One-cycle time-base pulse |
| dbg_active | input | 1 | High while a debug probe is attached |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_en |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
The hardest state to reach is an expiry that follows the early warning, with the reset pulse timed to the cycle and the status surviving it. The bench programs a short limit, feeds, and walks the count down one tick at a time through the warning cycle into expiry. It then samples sys_rst_o on its first and last high cycles and on the first low cycle, and reads the status and the reloaded count afterwards. A broken disable sequence (arm, wrong key, then the right key) is the other case that is hard to reach, and the bench drives it directly before doing a proper disable.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [15:0] KEY_FEED    = 16'hFEED;
    localparam logic [15:0] KEY_ARM     = 16'h2BAD;
    localparam logic [15:0] KEY_STOP    = 16'hCAFE;
    localparam logic [15:0] KEY_RESUME  = 16'hACED;
    localparam logic [15:0] KEY_CLEAR   = 16'hE8B4;
    localparam logic [15:0] CODE_STOPPED = 16'hDABE;
    localparam logic [15:0] CODE_EXPIRED = 16'hCFE8;

    typedef enum logic [3:0] {
        SEL_FEED, SEL_LIMIT, SEL_ARM, SEL_STOP, SEL_STATUS, SEL_COUNT,
        SEL_DEBUG, SEL_RESUME, SEL_EVENT, SEL_MASK, SEL_FORCE, SEL_NONE
    } reg_sel_t;

    typedef struct packed {
        logic feed;
        logic resume;
        logic stop;
        logic clr_status;
        logic set_evt;
        logic clr_evt;
    } ctl_t;

    function automatic reg_sel_t sel_of(input int unsigned word, input logic aligned);
        reg_sel_t s;
        if (!aligned) s = SEL_NONE;
        else begin
            case (word)
                0:  s = SEL_FEED;
                1:  s = SEL_LIMIT;
                2:  s = SEL_ARM;
                3:  s = SEL_STOP;
                4:  s = SEL_STATUS;
                5:  s = SEL_COUNT;
                6:  s = SEL_DEBUG;
                7:  s = SEL_RESUME;
                8:  s = SEL_EVENT;
                9:  s = SEL_MASK;
                10: s = SEL_FORCE;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
    import kwdt_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CNT_W       = 15,
    parameter int DEF_TIMEOUT = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [CNT_W-1:0]  count_q,
    input  logic              unstable,
    input  logic              enabled_q,
    input  logic              timed_out_q,
    input  logic              event_q,
    input  logic              dbg_active,
    output logic [15:0]       bus_rdata,
    output ctl_t              ctl,
    output logic [CNT_W-1:0]  limit_q,
    output logic              mask_q,
    output logic              keep_q,
    output logic              arm_q
);
    localparam int PAD_W = 16 - CNT_W;

    reg_sel_t sel;
    logic     wr;

    assign sel = sel_of(int'(bus_addr[ADDR_W-1:2]), bus_addr[1:0] == 2'b00);
    assign wr  = bus_en && bus_we;

    always_comb begin
        ctl            = '0;
        ctl.feed       = wr && sel == SEL_FEED   && bus_wdata == KEY_FEED;
        ctl.resume     = wr && sel == SEL_RESUME && bus_wdata == KEY_RESUME;
        ctl.stop       = wr && sel == SEL_STOP   && bus_wdata == KEY_STOP && arm_q;
        ctl.clr_status = wr && sel == SEL_STATUS && bus_wdata == KEY_CLEAR;
        ctl.set_evt    = wr && sel == SEL_FORCE  && bus_wdata[0];
        ctl.clr_evt    = wr && sel == SEL_EVENT  && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= CNT_W'(DEF_TIMEOUT);
            mask_q  <= 1'b0;
            keep_q  <= 1'b0;
            arm_q   <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_LIMIT: limit_q <= bus_wdata[CNT_W-1:0];
                SEL_MASK:  mask_q  <= bus_wdata[0];
                SEL_DEBUG: keep_q  <= bus_wdata[0];
                SEL_ARM:   arm_q   <= (bus_wdata == KEY_ARM);
                SEL_STOP:  arm_q   <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_LIMIT:  bus_rdata = {{PAD_W{1'b0}}, limit_q};
                SEL_STOP:   bus_rdata = enabled_q ? 16'h0000 : CODE_STOPPED;
                SEL_STATUS: bus_rdata = timed_out_q ? CODE_EXPIRED : 16'h0000;
                SEL_COUNT:  bus_rdata = {unstable, {(PAD_W-1){1'b0}}, count_q};
                SEL_DEBUG:  bus_rdata = {14'd0, dbg_active, keep_q};
                SEL_EVENT:  bus_rdata = {15'd0, event_q};
                SEL_MASK:   bus_rdata = {15'd0, mask_q};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int DEF_TIMEOUT = 6000,
    parameter int RST_CYCLES  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             dbg_active,
    input  logic             keep_q,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] limit_q,
    output logic [CNT_W-1:0] count_q,
    output logic             enabled_q,
    output logic             timed_out_q,
    output logic             unstable,
    output logic             warn,
    output logic             sys_rst_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic            running;
    logic            step;
    logic            expire;
    logic [RC_W-1:0] rcnt_q;

    assign running  = enabled_q && (!dbg_active || keep_q);
    assign step     = tick_en && running;
    assign unstable = step;
    assign expire   = step && !ctl.feed && (count_q <= CNT_W'(1));
    assign warn     = step && !ctl.feed && (count_q == CNT_W'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= CNT_W'(DEF_TIMEOUT);
            enabled_q   <= 1'b0;
            timed_out_q <= 1'b0;
            rcnt_q      <= '0;
        end else begin
            if (ctl.feed || expire) count_q <= limit_q;
            else if (step)          count_q <= count_q - CNT_W'(1);

            if (ctl.stop)        enabled_q <= 1'b0;
            else if (ctl.resume) enabled_q <= 1'b1;

            if (expire)              timed_out_q <= 1'b1;
            else if (ctl.clr_status) timed_out_q <= 1'b0;

            if (expire)                rcnt_q <= RC_W'(RST_CYCLES);
            else if (rcnt_q != '0)     rcnt_q <= rcnt_q - RC_W'(1);
        end
    end

    assign sys_rst_o = (rcnt_q != '0);
endmodule

// File: rtl/kwdt_irq.sv
module kwdt_irq
    import kwdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic warn,
    input  ctl_t ctl,
    input  logic mask_q,
    output logic event_q,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst)                       event_q <= 1'b0;
        else if (warn || ctl.set_evt)  event_q <= 1'b1;
        else if (ctl.clr_evt)          event_q <= 1'b0;
    end

    assign irq_o = event_q && mask_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CNT_W       = 15,
    parameter int DEF_TIMEOUT = 6000,
    parameter int RST_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              dbg_active,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    ctl_t             ctl;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic             unstable, enabled_q, timed_out_q, event_q;
    logic             mask_q, keep_q, arm_q, warn;

    kwdt_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_q(count_q),
        .unstable(unstable), .enabled_q(enabled_q), .timed_out_q(timed_out_q),
        .event_q(event_q), .dbg_active(dbg_active), .bus_rdata(bus_rdata),
        .ctl(ctl), .limit_q(limit_q), .mask_q(mask_q), .keep_q(keep_q),
        .arm_q(arm_q)
    );

    kwdt_core #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_active(dbg_active),
        .keep_q(keep_q), .ctl(ctl), .limit_q(limit_q), .count_q(count_q),
        .enabled_q(enabled_q), .timed_out_q(timed_out_q), .unstable(unstable),
        .warn(warn), .sys_rst_o(sys_rst_o)
    );

    kwdt_irq u_irq (
        .clk(clk), .rst(rst), .warn(warn), .ctl(ctl), .mask_q(mask_q),
        .event_q(event_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              dbg_active,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  limit_q,
    input logic              enabled_q,
    input logic              arm_q,
    input logic              keep_q,
    input logic              mask_q,
    input logic              timed_out_q
);
    logic wr_feed, wr_stop;
    assign wr_feed = bus_en && bus_we && bus_addr == ADDR_W'(6'h00);
    assign wr_stop = bus_en && bus_we && bus_addr == ADDR_W'(6'h0C);

    p_feed_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_feed && bus_wdata == KEY_FEED) |=> (count_q == $past(limit_q)));

    p_bad_feed_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_feed && bus_wdata != KEY_FEED && !tick_en) |=> $stable(count_q));

    p_stop_seq_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stop && bus_wdata == KEY_STOP && arm_q) |=> !enabled_q);

    p_status_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> timed_out_q);

    p_debug_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_en && dbg_active && !keep_q && !wr_feed) |=> $stable(count_q));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> mask_q);
endmodule

bind keyed_watchdog kwdt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_active(dbg_active),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o), .count_q(count_q), .limit_q(limit_q),
    .enabled_q(enabled_q), .arm_q(arm_q), .keep_q(keep_q), .mask_q(mask_q),
    .timed_out_q(timed_out_q)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    localparam int ADDR_W = 6;
    localparam int DEF_TO = 100;
    localparam int RSTC   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              dbg_active = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq_o;
    logic              sys_rst_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    keyed_watchdog #(.ADDR_W(ADDR_W), .CNT_W(15), .DEF_TIMEOUT(DEF_TO), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_active(dbg_active),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    always begin
        @(negedge clk);
        #2;
        if (bus_en && !bus_we) begin
            if (exp_q.size() != 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag,
                      input logic with_tick = 1'b0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; tick_en = with_tick;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic port_chk(input logic got, input logic exp, input string tag);
        #2;
        chk({15'd0, got}, {15'd0, exp}, tag);
    endtask

    initial begin : watchdog_timer
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        port_chk(irq_o, 1'b0, "R1 irq");
        port_chk(sys_rst_o, 1'b0, "R1 sys_rst");
        rd(6'h0C, 16'hDABE, "R1 stopped code");
        rd(6'h10, 16'h0000, "R1 status");
        rd(6'h14, 16'(DEF_TO), "R1 count");
        rd(6'h04, 16'(DEF_TO), "R1 limit");
        rd(6'h20, 16'h0000, "R1 event");
        tick();
        rd(6'h14, 16'(DEF_TO), "R1 stopped ignores tick");

        // R11 write-only / unmapped / misaligned
        rd(6'h00, 16'h0000, "R11 feed reads 0");
        rd(6'h08, 16'h0000, "R11 arm reads 0");
        rd(6'h1C, 16'h0000, "R11 resume reads 0");
        rd(6'h2C, 16'h0000, "R11 unmapped");
        rd(6'h05, 16'h0000, "R11 misaligned");
        wr(6'h07, 16'h1234);
        rd(6'h04, 16'(DEF_TO), "R11 misaligned write ignored");

        // R3 limit width
        wr(6'h04, 16'hFFFF);
        rd(6'h04, 16'h7FFF, "R3 bit15 dropped");
        wr(6'h04, 16'd5);
        rd(6'h04, 16'd5, "R3 readback");

        // R5 resume
        wr(6'h1C, 16'hACED);
        rd(6'h0C, 16'h0000, "R5 running code");
        rd(6'h14, 16'(DEF_TO), "R5 count held");

        // R2 feed
        wr(6'h00, 16'h1234);
        rd(6'h14, 16'(DEF_TO), "R2 wrong key ignored");
        wr(6'h00, 16'hFEED);
        rd(6'h14, 16'd5, "R2 reload");

        // R7 unstable flag during tick
        rd(6'h14, 16'h8005, "R7 unstable during tick", 1'b1);
        rd(6'h14, 16'h0004, "R7 stable after tick");

        // R9 warning
        wr(6'h24, 16'h0001);
        tick(); tick();
        rd(6'h20, 16'h0000, "R9 no event at count 2");
        tick();
        rd(6'h20, 16'h0001, "R9 event at count 1");
        port_chk(irq_o, 1'b1, "R9 irq set");
        wr(6'h20, 16'h0001);
        rd(6'h20, 16'h0000, "R9 event cleared");
        port_chk(irq_o, 1'b0, "R9 irq cleared");

        // R6 expiry
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        port_chk(sys_rst_o, 1'b1, "R6 pulse first");
        repeat (RSTC - 1) @(negedge clk);
        port_chk(sys_rst_o, 1'b1, "R6 pulse last");
        @(negedge clk);
        port_chk(sys_rst_o, 1'b0, "R6 pulse end");
        rd(6'h10, 16'hCFE8, "R6 status set");
        rd(6'h14, 16'd5, "R6 reloaded");
        wr(6'h10, 16'h1111);
        rd(6'h10, 16'hCFE8, "R6 wrong clear ignored");
        wr(6'h10, 16'hE8B4);
        rd(6'h10, 16'h0000, "R6 status cleared");

        // R8 debug freeze
        dbg_active = 1'b1;
        tick();
        rd(6'h14, 16'd5, "R8 frozen");
        rd(6'h18, 16'h0002, "R8 debug indication");
        wr(6'h18, 16'h0001);
        rd(6'h18, 16'h0003, "R8 keep bit");
        tick();
        rd(6'h14, 16'd4, "R8 keep counts");
        dbg_active = 1'b0;
        wr(6'h18, 16'h0000);

        // R4 disable sequence
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'h0000, "R4 unarmed stop ignored");
        wr(6'h08, 16'h2BAD);
        wr(6'h0C, 16'h1234);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'h0000, "R4 broken sequence");
        wr(6'h08, 16'h2BAD);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'hDABE, "R4 stopped");
        tick();
        rd(6'h14, 16'd4, "R4 stopped holds");

        // R5 resume from held count
        wr(6'h1C, 16'hACED);
        tick();
        rd(6'h14, 16'd3, "R5 resumes");

        // R10 force
        wr(6'h28, 16'h0001);
        rd(6'h20, 16'h0001, "R10 forced event");
        port_chk(irq_o, 1'b1, "R10 irq");
        rd(6'h28, 16'h0000, "R10 reads 0");
        wr(6'h24, 16'h0000);
        port_chk(irq_o, 1'b0, "R9 masked");
        rd(6'h24, 16'h0000, "R9 mask readback");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule